// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache. Each entry covers one pair of adjacent virtual pages, an even page and an odd page, and the pair shares one virtual page-pair number, one address-space tag and one global flag. Each half of the pair has its own frame number, valid flag and dirty flag. A per-entry size mask sets the page size for that entry, from 4 KB up to 16 MB, so entries with small and large pages can sit together in the same table.

Software-visible control logic loads an entry through the write port by giving an index. The memory pipeline presents a virtual address, the current address-space tag and a read/write flag on the lookup port. One clock later the block returns one of two results. The first is a physical address with a read-only or read/write grant. The second is a fault code with a flag that says whether the fault was a table miss (a refill case) or a hit on an unusable entry.

Top module: `tlb_pair_top`

## Requirements
- R1: After reset, no entry is loaded and the response outputs are low. A lookup issued before any write misses and returns the refill fault.
- R2: A write loads the entry selected by `wrIndex` at the clock edge. A lookup issued in the same cycle as a write still sees the contents that were in place before that write.
- R3: The 12-bit size mask takes the values 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF. These give page shifts of 12, 14, 16, 18, 20, 22 and 24. A zero mask means 4 KB pages.
- R4: The stored page-pair field holds virtual address bits 31..13. An entry matches when the address bits from position shift+1 upwards equal the stored bits at the same positions, and either the address-space tags are equal or the entry's global flag is set. Stored bits below shift+1 have no effect.
- R5: Address bit [shift] picks the odd half of the entry when it is 1 and the even half when it is 0.
- R6: On a usable hit, the physical address is (frame << 12) OR (address AND (2^shift − 1)). The grant is read/write (`rspRw`=1) when the selected dirty flag is set, and read-only when it is clear.
- R7: A hit whose selected valid flag is clear faults. The code is 2 (load) for a read and 3 (store) for a write, and the refill flag is 0.
- R8: A write that hits a valid half with a clear dirty flag faults with code 1 (modification), and the refill flag is 0.
- R9: When no entry matches, the lookup faults with code 2 for a read or 3 for a write, and the refill flag is 1.
- R10: When several entries match, the entry with the lowest index supplies the result.
- R11: `rspValid` is high in exactly the cycle after each cycle in which `reqValid` is high, and the result fields are valid in that same cycle.
- R12: When `rspFault` is high, `rspPaddr` is 0 and `rspRw` is 0. When `rspFault` is low, `rspExc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Load one entry this cycle |
| wrIndex | input | IDXW | Index of the entry to load |
| wrMask | input | MASKW | Page size mask |
| wrVpn2 | input | VAW-13 | Virtual page-pair number (address bits 31..13) |
| wrAsid | input | ASIDW | Address-space tag |
| wrGlobal | input | 1 | Match any address-space tag |
| wrPfnEven | input | PFNW | Frame number for the even page |
| wrValidEven | input | 1 | Even page valid |
| wrDirtyEven | input | 1 | Even page writable |
| wrPfnOdd | input | PFNW | Frame number for the odd page |
| wrValidOdd | input | 1 | Odd page valid |
| wrDirtyOdd | input | 1 | Odd page writable |
| reqValid | input | 1 | Lookup strobe |
| reqVaddr | input | VAW | Virtual address to translate |
| reqAsid | input | ASIDW | Current address-space tag |
| reqWrite | input | 1 | Access is a store |
| rspValid | output | 1 | Result present |
| rspPaddr | output | PFNW+12 | Physical address |
| rspRw | output | 1 | 1 = read/write grant, 0 = read-only |
| rspFault | output | 1 | Translation failed |
| rspExc | output | 2 | 0 none, 1 modification, 2 load fault, 3 store fault |
| rspRefill | output | 1 | Fault came from a table miss |

## Verification
The bound checker watches every cycle for the properties that hold on any result. These are the one-cycle response timing, a refill flag that only appears with a load or store fault, a modification fault that only follows a write, a fault code whose load or store type agrees with the access, and the zeroed address and grant on a fault. Some behaviour can only be shown by comparing results against a model of the loaded table, so the bench's scenarios cover it. This includes the page-size decoding for every mask value, the choice between the even and odd half, the offset and frame merge, address-space and global matching, lowest-index priority among overlapping entries, and the order between a write and a lookup in the same cycle.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_MOD  = 2'd1,
    EXC_TLBL = 2'd2,
    EXC_TLBS = 2'd3
  } excCode_e;

  typedef struct packed {
    logic     loadEntry;
    logic     captureResp;
    logic     fault;
    logic     grantRw;
    logic     refill;
    excCode_e exc;
  } ctlStrobes_t;

endpackage

// File: rtl/tlb_pair_ctrl.sv
module tlb_pair_ctrl
  import tlb_pair_pkg::*;
(
  input  logic        wrEn,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        anyHit,
  input  logic        selValid,
  input  logic        selDirty,
  output ctlStrobes_t strb
);

  always_comb begin
    strb             = '0;
    strb.loadEntry   = wrEn;
    strb.captureResp = reqValid;
    strb.exc         = EXC_NONE;
    if (!anyHit) begin
      strb.fault  = 1'b1;
      strb.refill = 1'b1;
      strb.exc    = reqWrite ? EXC_TLBS : EXC_TLBL;
    end else if (!selValid) begin
      strb.fault = 1'b1;
      strb.exc   = reqWrite ? EXC_TLBS : EXC_TLBL;
    end else if (reqWrite && !selDirty) begin
      strb.fault = 1'b1;
      strb.exc   = EXC_MOD;
    end else begin
      strb.grantRw = selDirty;
    end
  end

endmodule

// File: rtl/tlb_pair_dp.sv
module tlb_pair_dp
  import tlb_pair_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VAW     = 32,
  parameter int PFNW    = 20,
  parameter int ASIDW   = 8,
  parameter int MASKW   = 12,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPNW   = VAW - 13,
  localparam int PAW    = PFNW + 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [IDXW-1:0]   wrIndex,
  input  logic [MASKW-1:0]  wrMask,
  input  logic [VPNW-1:0]   wrVpn2,
  input  logic [ASIDW-1:0]  wrAsid,
  input  logic              wrGlobal,
  input  logic [PFNW-1:0]   wrPfnEven,
  input  logic              wrValidEven,
  input  logic              wrDirtyEven,
  input  logic [PFNW-1:0]   wrPfnOdd,
  input  logic              wrValidOdd,
  input  logic              wrDirtyOdd,
  input  logic [VAW-1:0]    reqVaddr,
  input  logic [ASIDW-1:0]  reqAsid,
  output logic              anyHit,
  output logic              selValid,
  output logic              selDirty,
  output logic              rspValid,
  output logic [PAW-1:0]    rspPaddr,
  output logic              rspRw,
  output logic              rspFault,
  output excCode_e          rspExc,
  output logic              rspRefill
);

  localparam int PADW = VAW - 12 - MASKW;
  localparam int VPADW = VPNW - MASKW;

  logic             entLoaded [ENTRIES];
  logic [MASKW-1:0] entMask   [ENTRIES];
  logic [VPNW-1:0]  entVpn    [ENTRIES];
  logic [ASIDW-1:0] entAsid   [ENTRIES];
  logic             entGlob   [ENTRIES];
  logic [PFNW-1:0]  entPfnE   [ENTRIES];
  logic             entValE   [ENTRIES];
  logic             entDirE   [ENTRIES];
  logic [PFNW-1:0]  entPfnO   [ENTRIES];
  logic             entValO   [ENTRIES];
  logic             entDirO   [ENTRIES];

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] oddVec;
  logic [VAW-1:0]     offMask [ENTRIES];

  // Entry storage, loaded by index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entLoaded[i] <= 1'b0;
        entMask[i]   <= '0;
        entVpn[i]    <= '0;
        entAsid[i]   <= '0;
        entGlob[i]   <= 1'b0;
        entPfnE[i]   <= '0;
        entValE[i]   <= 1'b0;
        entDirE[i]   <= 1'b0;
        entPfnO[i]   <= '0;
        entValO[i]   <= 1'b0;
        entDirO[i]   <= 1'b0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.loadEntry && (wrIndex == IDXW'(i))) begin
          entLoaded[i] <= 1'b1;
          entMask[i]   <= wrMask;
          entVpn[i]    <= wrVpn2;
          entAsid[i]   <= wrAsid;
          entGlob[i]   <= wrGlobal;
          entPfnE[i]   <= wrPfnEven;
          entValE[i]   <= wrValidEven;
          entDirE[i]   <= wrDirtyEven;
          entPfnO[i]   <= wrPfnOdd;
          entValO[i]   <= wrValidOdd;
          entDirO[i]   <= wrDirtyOdd;
        end
      end
    end
  end

  // Per-entry compare: thermometer mask doubles as offset mask and compare mask
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [VPNW-1:0] careBits;
    assign offMask[g]  = {{PADW{1'b0}}, entMask[g], 12'hFFF};
    assign careBits    = ~{{VPADW{1'b0}}, entMask[g]};
    assign hitVec[g]   = entLoaded[g]
                       && (((reqVaddr[VAW-1:13] ^ entVpn[g]) & careBits) == '0)
                       && ((entAsid[g] == reqAsid) || entGlob[g]);
    assign oddVec[g]   = |(reqVaddr & (offMask[g] + VAW'(1)));
  end

  // Lowest index wins
  logic [IDXW-1:0] selIdx;
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        selIdx = IDXW'(i);
      end
    end
  end

  logic            selOdd;
  logic [PFNW-1:0] selPfn;
  logic [VAW-1:0]  selOff;
  logic [PAW-1:0]  xlatePaddr;

  assign selOdd     = oddVec[selIdx];
  assign selValid   = selOdd ? entValO[selIdx] : entValE[selIdx];
  assign selDirty   = selOdd ? entDirO[selIdx] : entDirE[selIdx];
  assign selPfn     = selOdd ? entPfnO[selIdx] : entPfnE[selIdx];
  assign selOff     = offMask[selIdx];
  assign xlatePaddr = {selPfn, 12'h000} | PAW'(reqVaddr & selOff);

  // Response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspPaddr  <= '0;
      rspRw     <= 1'b0;
      rspFault  <= 1'b0;
      rspExc    <= EXC_NONE;
      rspRefill <= 1'b0;
    end else begin
      rspValid <= strb.captureResp;
      if (strb.captureResp) begin
        rspPaddr  <= strb.fault ? '0 : xlatePaddr;
        rspRw     <= strb.grantRw;
        rspFault  <= strb.fault;
        rspExc    <= strb.exc;
        rspRefill <= strb.refill;
      end else begin
        rspPaddr  <= '0;
        rspRw     <= 1'b0;
        rspFault  <= 1'b0;
        rspExc    <= EXC_NONE;
        rspRefill <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlb_pair_top.sv
module tlb_pair_top
  import tlb_pair_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VAW     = 32,
  parameter int PFNW    = 20,
  parameter int ASIDW   = 8,
  parameter int MASKW   = 12,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPNW   = VAW - 13,
  localparam int PAW    = PFNW + 12
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDXW-1:0]  wrIndex,
  input  logic [MASKW-1:0] wrMask,
  input  logic [VPNW-1:0]  wrVpn2,
  input  logic [ASIDW-1:0] wrAsid,
  input  logic             wrGlobal,
  input  logic [PFNW-1:0]  wrPfnEven,
  input  logic             wrValidEven,
  input  logic             wrDirtyEven,
  input  logic [PFNW-1:0]  wrPfnOdd,
  input  logic             wrValidOdd,
  input  logic             wrDirtyOdd,
  input  logic             reqValid,
  input  logic [VAW-1:0]   reqVaddr,
  input  logic [ASIDW-1:0] reqAsid,
  input  logic             reqWrite,
  output logic             rspValid,
  output logic [PAW-1:0]   rspPaddr,
  output logic             rspRw,
  output logic             rspFault,
  output logic [1:0]       rspExc,
  output logic             rspRefill
);

  ctlStrobes_t strb;
  logic        anyHit;
  logic        selValid;
  logic        selDirty;
  excCode_e    excReg;

  tlb_pair_ctrl u_ctrl (
    .wrEn     (wrEn),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .anyHit   (anyHit),
    .selValid (selValid),
    .selDirty (selDirty),
    .strb     (strb)
  );

  tlb_pair_dp #(
    .ENTRIES (ENTRIES),
    .VAW     (VAW),
    .PFNW    (PFNW),
    .ASIDW   (ASIDW),
    .MASKW   (MASKW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrIndex     (wrIndex),
    .wrMask      (wrMask),
    .wrVpn2      (wrVpn2),
    .wrAsid      (wrAsid),
    .wrGlobal    (wrGlobal),
    .wrPfnEven   (wrPfnEven),
    .wrValidEven (wrValidEven),
    .wrDirtyEven (wrDirtyEven),
    .wrPfnOdd    (wrPfnOdd),
    .wrValidOdd  (wrValidOdd),
    .wrDirtyOdd  (wrDirtyOdd),
    .reqVaddr    (reqVaddr),
    .reqAsid     (reqAsid),
    .anyHit      (anyHit),
    .selValid    (selValid),
    .selDirty    (selDirty),
    .rspValid    (rspValid),
    .rspPaddr    (rspPaddr),
    .rspRw       (rspRw),
    .rspFault    (rspFault),
    .rspExc      (excReg),
    .rspRefill   (rspRefill)
  );

  assign rspExc = excReg;

endmodule

// File: rtl/tlb_pair_checker.sv
module tlb_pair_checker #(
  parameter int PAW = 32
)(
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic           reqWrite,
  input logic           rspValid,
  input logic [PAW-1:0] rspPaddr,
  input logic           rspRw,
  input logic           rspFault,
  input logic [1:0]     rspExc,
  input logic           rspRefill
);

  assert_resp_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rspValid == $past(reqValid)));

  assert_refill_is_tlb_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRefill) |-> (rspFault && rspExc[1]));

  assert_mod_after_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rspValid && rspExc == 2'd1) |-> ($past(reqWrite) && !rspRefill));

  assert_store_type_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rspValid && rspExc[1]) |-> (rspExc[0] == $past(reqWrite)));

  assert_fault_zeroes_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPaddr == '0 && !rspRw && rspValid));

  assert_no_code_on_grant_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspExc == 2'd0 && !rspRefill));

endmodule

bind tlb_pair_top tlb_pair_checker #(.PAW(PAW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .rspValid  (rspValid),
  .rspPaddr  (rspPaddr),
  .rspRw     (rspRw),
  .rspFault  (rspFault),
  .rspExc    (rspExc),
  .rspRefill (rspRefill)
);

// File: tb/sim_tlb_pair_top.sv
`timescale 1ns/1ps
module sim_tlb_pair_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIndex = '0;
  logic [11:0] wrMask = '0;
  logic [18:0] wrVpn2 = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic [19:0] wrPfnEven = '0;
  logic        wrValidEven = 1'b0;
  logic        wrDirtyEven = 1'b0;
  logic [19:0] wrPfnOdd = '0;
  logic        wrValidOdd = 1'b0;
  logic        wrDirtyOdd = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [7:0]  reqAsid = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspRw;
  logic        rspFault;
  logic [1:0]  rspExc;
  logic        rspRefill;

  always #2 clk = ~clk;

  tlb_pair_top #(.ENTRIES(N)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIndex(wrIndex), .wrMask(wrMask),
    .wrVpn2(wrVpn2), .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrPfnEven(wrPfnEven), .wrValidEven(wrValidEven), .wrDirtyEven(wrDirtyEven),
    .wrPfnOdd(wrPfnOdd), .wrValidOdd(wrValidOdd), .wrDirtyOdd(wrDirtyOdd),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqAsid(reqAsid), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspRw(rspRw), .rspFault(rspFault),
    .rspExc(rspExc), .rspRefill(rspRefill)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side picture of the loaded table
  bit          mLoaded [N];
  logic [11:0] mMask [N];
  logic [18:0] mVpn  [N];
  logic [7:0]  mAsid [N];
  bit          mGlob [N];
  logic [19:0] mPfnE [N];
  bit          mValE [N];
  bit          mDirE [N];
  logic [19:0] mPfnO [N];
  bit          mValO [N];
  bit          mDirO [N];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int shiftOf(input logic [11:0] m);
    case (m)
      12'h000: return 12;
      12'h003: return 14;
      12'h00F: return 16;
      12'h03F: return 18;
      12'h0FF: return 20;
      12'h3FF: return 22;
      default: return 24;
    endcase
  endfunction

  task automatic model(input logic [31:0] va, input logic [7:0] asid, input bit wr,
                       output bit f, output logic [1:0] e, output bit rf,
                       output bit rw, output logic [31:0] pa);
    int hitIdx;
    int sh;
    bit odd;
    bit v;
    bit d;
    logic [19:0] pfn;
    hitIdx = -1;
    for (int i = 0; i < N; i++) begin
      if (hitIdx < 0 && mLoaded[i]) begin
        sh = shiftOf(mMask[i]);
        if (((va >> (sh + 1)) == ({mVpn[i], 13'h0} >> (sh + 1))) &&
            (mAsid[i] == asid || mGlob[i]))
          hitIdx = i;
      end
    end
    f = 0; e = 2'd0; rf = 0; rw = 0; pa = '0;
    if (hitIdx < 0) begin
      f = 1; rf = 1; e = wr ? 2'd3 : 2'd2;
    end else begin
      sh  = shiftOf(mMask[hitIdx]);
      odd = va[sh];
      v   = odd ? mValO[hitIdx] : mValE[hitIdx];
      d   = odd ? mDirO[hitIdx] : mDirE[hitIdx];
      pfn = odd ? mPfnO[hitIdx] : mPfnE[hitIdx];
      if (!v) begin
        f = 1; e = wr ? 2'd3 : 2'd2;
      end else if (wr && !d) begin
        f = 1; e = 2'd1;
      end else begin
        rw = d;
        pa = {pfn, 12'h000} | (va & ((32'd1 << sh) - 32'd1));
      end
    end
  endtask

  task automatic driveWrite(input int idx, input logic [11:0] m, input logic [18:0] vpn,
                            input logic [7:0] asid, input bit g,
                            input logic [19:0] pe, input bit ve, input bit de,
                            input logic [19:0] po, input bit vo, input bit dox);
    wrEn = 1; wrIndex = 3'(idx); wrMask = m; wrVpn2 = vpn; wrAsid = asid; wrGlobal = g;
    wrPfnEven = pe; wrValidEven = ve; wrDirtyEven = de;
    wrPfnOdd = po; wrValidOdd = vo; wrDirtyOdd = dox;
  endtask

  task automatic commitModel(input int idx, input logic [11:0] m, input logic [18:0] vpn,
                             input logic [7:0] asid, input bit g,
                             input logic [19:0] pe, input bit ve, input bit de,
                             input logic [19:0] po, input bit vo, input bit dox);
    mLoaded[idx] = 1; mMask[idx] = m; mVpn[idx] = vpn; mAsid[idx] = asid; mGlob[idx] = g;
    mPfnE[idx] = pe; mValE[idx] = ve; mDirE[idx] = de;
    mPfnO[idx] = po; mValO[idx] = vo; mDirO[idx] = dox;
  endtask

  task automatic writeEntry(input int idx, input logic [11:0] m, input logic [18:0] vpn,
                            input logic [7:0] asid, input bit g,
                            input logic [19:0] pe, input bit ve, input bit de,
                            input logic [19:0] po, input bit vo, input bit dox);
    @(negedge clk);
    driveWrite(idx, m, vpn, asid, g, pe, ve, de, po, vo, dox);
    @(negedge clk);
    wrEn = 0;
    commitModel(idx, m, vpn, asid, g, pe, ve, de, po, vo, dox);
  endtask

  task automatic checkResp(input string tag, input bit f, input logic [1:0] e,
                           input bit rf, input bit rw, input logic [31:0] pa);
    chk("R11", "rspValid", 32'(rspValid), 32'd1);
    chk(tag, "rspFault", 32'(rspFault), 32'(f));
    chk(tag, "rspExc", 32'(rspExc), 32'(e));
    chk(tag, "rspRefill", 32'(rspRefill), 32'(rf));
    chk(f ? "R12" : tag, "rspRw", 32'(rspRw), 32'(rw));
    chk(f ? "R12" : tag, "rspPaddr", rspPaddr, pa);
  endtask

  task automatic lookup(input string tag, input logic [31:0] va,
                        input logic [7:0] asid, input bit wr);
    bit f; logic [1:0] e; bit rf; bit rw; logic [31:0] pa;
    model(va, asid, wr, f, e, rf, rw, pa);
    @(negedge clk);
    reqValid = 1; reqVaddr = va; reqAsid = asid; reqWrite = wr;
    @(negedge clk);
    reqValid = 0;
    checkResp(tag, f, e, rf, rw, pa);
  endtask

  function automatic logic [31:0] pageAddr(input int k, input bit odd, input logic [31:0] off);
    int sh;
    logic [31:0] base;
    sh = shiftOf(mMask[k]);
    base = {mVpn[k], 13'h0};
    base = (base >> (sh + 1)) << (sh + 1);
    return base | (32'(odd) << sh) | (off & ((32'd1 << sh) - 32'd1));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit f; logic [1:0] e; bit rf; bit rw; logic [31:0] pa;
    for (int i = 0; i < N; i++) mLoaded[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rspValid in reset", 32'(rspValid), 32'd0);
    chk("R1", "rspFault in reset", 32'(rspFault), 32'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1", "rspValid after reset", 32'(rspValid), 32'd0);
    lookup("R1", 32'h0000_0000, 8'h00, 0);
    lookup("R9", 32'h8000_1234, 8'h00, 1);

    // Load one entry per page size: masks 0x000..0xFFF (R3)
    for (int k = 0; k < 7; k++) begin
      writeEntry(k, 12'((1 << (2 * k)) - 1), 19'(((k + 1) << 14) | 'h155), 8'h05, 0,
                 20'(32'hA0010 | (k << 8)), 1, k[0],
                 20'(32'hB0020 | (k << 8)), (k != 2), !k[0]);
    end
    writeEntry(7, 12'h000, 19'h60003, 8'h3C, 1, 20'hC1234, 1, 1, 20'hC5678, 1, 1);

    // Sweep: size, half, access type, offset (R3-R8)
    for (int k = 0; k < 7; k++) begin
      for (int odd = 0; odd < 2; odd++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int o = 0; o < 3; o++) begin
            logic [31:0] off;
            off = (o == 0) ? 32'h0 : (o == 1) ? 32'hFFFF_FFFF : 32'h00A5_A5A5;
            lookup(!mValE[k] || !mValO[k] ? "R7" : (wr == 1 ? "R8" : "R6"),
                   pageAddr(k, odd[0], off), 8'h05, wr[0]);
          end
        end
      end
      // outside the pair: flip the lowest compared bit (R4, R9)
      lookup("R9", pageAddr(k, 0, 0) ^ (32'd1 << (shiftOf(mMask[k]) + 1)), 8'h05, 0);
      lookup("R9", pageAddr(k, 1, 0) ^ (32'd1 << (shiftOf(mMask[k]) + 1)), 8'h05, 1);
    end

    // R4: tag mismatch misses, global entry ignores tag
    lookup("R4", pageAddr(3, 0, 32'h10), 8'h06, 0);
    lookup("R4", pageAddr(7, 1, 32'h10), 8'h77, 1);
    lookup("R5", pageAddr(7, 0, 32'hFFF), 8'h00, 0);

    // R10: entry 6 overlaps entry 7 and wins
    writeEntry(6, 12'h000, 19'h60003, 8'h00, 1, 20'h12345, 1, 0, 20'h23456, 1, 1);
    lookup("R10", pageAddr(7, 0, 32'h123), 8'h3C, 0);
    lookup("R10", pageAddr(7, 1, 32'h456), 8'h11, 1);

    // R2: same-cycle write and lookup sees the old entry 0
    model(pageAddr(0, 0, 32'h77), 8'h05, 0, f, e, rf, rw, pa);
    @(negedge clk);
    driveWrite(0, 12'h000, mVpn[0], 8'h05, 0, 20'h55555, 1, 1, 20'h66666, 1, 1);
    reqValid = 1; reqVaddr = pageAddr(0, 0, 32'h77); reqAsid = 8'h05; reqWrite = 0;
    @(negedge clk);
    wrEn = 0; reqValid = 0;
    checkResp("R2", f, e, rf, rw, pa);
    commitModel(0, 12'h000, mVpn[0], 8'h05, 0, 20'h55555, 1, 1, 20'h66666, 1, 1);
    lookup("R2", pageAddr(0, 0, 32'h77), 8'h05, 0);
    lookup("R2", pageAddr(0, 1, 32'h77), 8'h05, 1);

    // R11: the response drops the cycle after a lone strobe
    @(negedge clk);
    chk("R11", "rspValid idle", 32'(rspValid), 32'd0);
    chk("R11", "rspFault idle", 32'(rspFault), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule